// File: doc/BRIEF.md
# Seven-Phase Periodic Timing Waveform Generator

This block produces seven control waveforms that all share a free-running period of exactly 256 clocks. The waveforms have fixed shapes. Four of them start each period low and go high a few clocks in. The other three start each period high and drop low a few clocks before the period ends. An internal 8-bit phase counter advances once on every enabled clock. Each output has its own flip-flop, and a small piece of edge logic sets or clears that flip-flop.

Every output comes directly from a flip-flop. An output therefore cannot glitch when several counter bits flip together, for example on the step from 127 to 128 or on the wrap from 255 to 0. Each edge cell decodes the phase one step before its edge position, so the registered level agrees with the phase number held in the counter during that same cycle.

Top module: `phase_wave_gen`

## Requirements
- R1: The phase advances by one on each enabled clock and wraps from 255 to 0, which gives a period of exactly 256 enabled clocks. The waveform pattern repeats with that period.
- R2: `wave_o[0]` is low at phases 0 to 4 and high at phases 5 to 255.
- R3: `wave_o[1]` is low at phases 0 to 3, `wave_o[2]` is low at phases 0 to 2 and `wave_o[3]` is low at phases 0 to 1. Each of them is high for the rest of the period.
- R4: `wave_o[4]` is high at phases 0 to 251 and low at phases 252 to 255.
- R5: `wave_o[5]` is high at phases 0 to 252 and `wave_o[6]` is high at phases 0 to 253. Each of them is low for the rest of the period.
- R6: A synchronous reset takes priority over enable. It sets the phase to 0 and loads every output with its phase-0 level, so that `wave_o` reads 7'b1110000.
- R7: While `en` is low, the phase and all outputs keep their values. The next enabled clock continues from the held phase.
- R8: Over any 256 consecutive enabled clocks, each output makes exactly one rising and one falling transition. An output changes only on the clock edge that follows a decode of its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, the phase and outputs hold |
| wave_o | output | 7 | Registered waveform outputs, bit i is waveform i+1 |

## Verification
A long continuous enabled run crosses two full periods, including the wraps at 127 to 128 and 255 to 0. This run separates a period of 256 from one of 255, and it also exposes an edge that is placed one phase early or late. A stuttering enable pattern, with gaps that fall across edge positions, shows whether the hold logic freezes the counter and the outputs together. A reset asserted during an enabled run checks that reset takes priority over enable and that the phase-0 levels are loaded. A transition count over one full period catches any output that has an extra edge or a missing edge.

// File: rtl/pwg_pkg.sv
`timescale 1ns/1ps
package pwg_pkg;

  localparam int unsigned PHASE_W   = 8;
  localparam int unsigned NUM_WAVES = 7;

  // Phase at which waveform idx first reads high.
  function automatic int unsigned rise_phase(int unsigned idx);
    case (idx)
      0: return 5;
      1: return 4;
      2: return 3;
      3: return 2;
      default: return 0;
    endcase
  endfunction

  // Phase at which waveform idx first reads low.
  function automatic int unsigned fall_phase(int unsigned idx);
    case (idx)
      4: return 252;
      5: return 253;
      6: return 254;
      default: return 0;
    endcase
  endfunction

  // Phase that comes one step before ph in a 2**w period.
  function automatic int unsigned prev_phase(int unsigned ph, int unsigned w);
    return (ph + (32'd1 << w) - 1) % (32'd1 << w);
  endfunction

  // Level of waveform idx at phase ph.
  function automatic logic level_at(int unsigned idx, int unsigned ph);
    int unsigned r;
    int unsigned f;
    r = rise_phase(idx);
    f = fall_phase(idx);
    if (r < f) return (ph >= r) && (ph < f);
    else       return (ph >= r) || (ph < f);
  endfunction

endpackage

// File: rtl/pwg_phase_ctr.sv
`timescale 1ns/1ps
module pwg_phase_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] phase_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)     phase_o <= '0;
    else if (en) phase_o <= phase_o + ONE;
  end

endmodule

// File: rtl/pwg_edge_cell.sv
`timescale 1ns/1ps
module pwg_edge_cell
  import pwg_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned RISE_AT = 0,
  parameter int unsigned FALL_AT = 0,
  parameter bit          INIT    = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] phase_i,
  output logic         wave_o,
  output logic         rise_evt_o,
  output logic         fall_evt_o
);

  // Decode one step early so the registered level matches the phase.
  localparam int unsigned  PRE_RISE_I = prev_phase(RISE_AT, W);
  localparam int unsigned  PRE_FALL_I = prev_phase(FALL_AT, W);
  localparam logic [W-1:0] PRE_RISE   = PRE_RISE_I[W-1:0];
  localparam logic [W-1:0] PRE_FALL   = PRE_FALL_I[W-1:0];

  assign rise_evt_o = en && (phase_i == PRE_RISE);
  assign fall_evt_o = en && (phase_i == PRE_FALL);

  always_ff @(posedge clk) begin
    if (rst)             wave_o <= INIT;
    else if (rise_evt_o) wave_o <= 1'b1;
    else if (fall_evt_o) wave_o <= 1'b0;
  end

endmodule

// File: rtl/phase_wave_gen.sv
`timescale 1ns/1ps
module phase_wave_gen
  import pwg_pkg::*;
#(
  parameter int unsigned PHASE_W = pwg_pkg::PHASE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  output logic [NUM_WAVES-1:0] wave_o
);

  logic [PHASE_W-1:0]   phase_q;
  logic [NUM_WAVES-1:0] rise_evt;
  logic [NUM_WAVES-1:0] fall_evt;

  pwg_phase_ctr #(.W(PHASE_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .phase_o (phase_q)
  );

  for (genvar g = 0; g < NUM_WAVES; g++) begin : g_wave
    pwg_edge_cell #(
      .W       (PHASE_W),
      .RISE_AT (rise_phase(g)),
      .FALL_AT (fall_phase(g)),
      .INIT    (level_at(g, 0))
    ) u_cell (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .phase_i    (phase_q),
      .wave_o     (wave_o[g]),
      .rise_evt_o (rise_evt[g]),
      .fall_evt_o (fall_evt[g])
    );
  end

endmodule

// File: rtl/pwg_checker.sv
`timescale 1ns/1ps
module pwg_checker #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 7
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [N-1:0] wave_o,
  input logic [W-1:0] phase,
  input logic [N-1:0] rise_evt,
  input logic [N-1:0] fall_evt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |-> (phase == $past(phase) + ONE)); // R1

  AST_RESET_LOAD: assert property (@(posedge clk)
    $past(rst) |-> (phase == '0 && wave_o == 7'b1110000)); // R6

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> ($stable(phase) && $stable(wave_o))); // R7

  AST_WAVE0_LEVEL: assert property (@(posedge clk) disable iff (rst)
    wave_o[0] == (phase > 8'd4)); // R2

  AST_EARLY_LEVELS: assert property (@(posedge clk) disable iff (rst)
    wave_o[3:1] == {phase > 8'd1, phase > 8'd2, phase > 8'd3}); // R3

  AST_WAVE4_LEVEL: assert property (@(posedge clk) disable iff (rst)
    wave_o[4] == (phase < 8'd252)); // R4

  AST_LATE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    wave_o[6:5] == {phase < 8'd254, phase < 8'd253}); // R5

  AST_EDGE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((wave_o ^ $past(wave_o)) == ($past(rise_evt | fall_evt)))); // R8

endmodule

bind phase_wave_gen pwg_checker #(.W(PHASE_W), .N(pwg_pkg::NUM_WAVES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .wave_o   (wave_o),
  .phase    (phase_q),
  .rise_evt (rise_evt),
  .fall_evt (fall_evt)
);

// File: tb/test_phase_wave_gen.sv
`timescale 1ns/1ps
module test_phase_wave_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [6:0] wave_o;

  int checks   = 0;
  int failures = 0;
  int ph_model = 0;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  phase_wave_gen i_phase_wave_gen (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .wave_o (wave_o)
  );

  // Expected levels, written from the requirement text.
  function automatic logic [6:0] ref_wave(int ph);
    logic [6:0] v;
    v[0] = (ph >= 5);
    v[1] = (ph >= 4);
    v[2] = (ph >= 3);
    v[3] = (ph >= 2);
    v[4] = (ph <= 251);
    v[5] = (ph <= 252);
    v[6] = (ph <= 253);
    return v;
  endfunction

  // Driver: apply inputs for one clock and queue the expected result.
  task automatic step(input logic r, input logic e, input string tag);
    item_t it;
    rst = r;
    en  = e;
    if (r)      ph_model = 0;
    else if (e) ph_model = (ph_model + 1) % 256;
    @(posedge clk);
    #1;
    it.exp = ref_wave(ph_model);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (wave_o !== it.exp) begin
        failures++;
        $display("FAIL %s: wave_o=%b expected=%b", it.tag, wave_o, it.exp);
      end
    end
  end

  function automatic string tag_for(int ph);
    if (ph <= 5)   return "R2 R3";
    if (ph >= 250) return "R4 R5";
    return "R1";
  endfunction

  initial begin
    int tog[7];
    logic [6:0] last;
    // R6: reset state
    repeat (3) step(1'b1, 1'b0, "R6");
    // R7: enable low right after reset holds the phase-0 levels
    repeat (2) step(1'b0, 1'b0, "R7");
    // R1..R5: continuous run across 127->128 and the 255->0 wrap
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1, tag_for((ph_model + 1) % 256));
    // R8: transition count over one full period
    for (int i = 0; i < 7; i++) tog[i] = 0;
    @(negedge clk);
    last = wave_o;
    for (int k = 0; k < 256; k++) begin
      step(1'b0, 1'b1, "R8");
      @(negedge clk);
      for (int i = 0; i < 7; i++) if (wave_o[i] != last[i]) tog[i]++;
      last = wave_o;
    end
    for (int i = 0; i < 7; i++) begin
      checks++;
      if (tog[i] != 2) begin
        failures++;
        $display("FAIL R8: output %0d transitions=%0d expected=2", i, tog[i]);
      end
    end
    // R7: stuttering enable across the early edges
    while (ph_model != 0) step(1'b0, 1'b1, "R1");
    for (int k = 0; k < 40; k++) step(1'b0, (k % 3) != 0, "R7");
    // R6: reset during an enabled run takes priority over enable
    step(1'b1, 1'b1, "R6");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, "R2 R3");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule